// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a single physical access may proceed. It receives a 34-bit physical address, an access kind (instruction fetch, data load or data store), the current privilege level, and the full contents of a sixteen-entry protection table. The table itself lives elsewhere and arrives as one packed configuration vector and one packed address-register vector. Each entry describes a region in one of three ways, and the block evaluates all sixteen in parallel. The lowest-indexed entry that covers the address decides the outcome.

The decision is combinational. It is captured in a flop, so the verdict for the inputs present before a rising clock edge is visible on `allow_q` after that edge. Machine mode may pass unlocked entries without regard to their permission bits. A locked entry applies its permission bits to every privilege level. The block does not translate pages or check the width of an access. It compares the page-aligned address only.

Top module: `pmp_checker`

## Requirements
- R1: While `rst_n` is low, `allow_q` is 0.
- R2: `allow_q` shows the verdict for the inputs sampled at the previous rising clock edge. Changing the inputs between edges does not alter `allow_q` until the next edge.
- R3: When every entry is off, the access is allowed if and only if `priv` is 2'b11 (machine).
- R4: The mode of an entry is configuration bits [4:3]: 0 is off, 1 is top-of-range, 2 is a 4-byte region, and 3 is a power-of-two region. An entry that is off never matches.
- R5: Among the entries that match, only the lowest index decides. A denial from that entry is not overridden by a higher entry.
- R6: A top-of-range entry i covers byte addresses from {areg[i-1],2'b00} up to but not including {areg[i],2'b00}. The previous register is used whatever its own mode is, and entry 0 uses zero. When the top is not above the base, the entry covers nothing.
- R7: A 4-byte entry covers the four bytes starting at {areg,2'b00}.
- R8: A power-of-two entry with t trailing ones in its address register covers 2^(t+3) bytes, aligned to that size, that contain {areg,2'b00}. A register of all ones covers the whole address space.
- R9: `acc_kind` 0 (fetch) uses configuration bit 2 (execute), 1 (load) uses bit 0 (read) and 2 (store) uses bit 1 (write). Kind 3 is reserved and is always denied.
- R10: If the deciding entry has its lock bit (bit 7) clear and `priv` is machine, the access is allowed. In every other case the entry's permission bit for the access kind decides.
- R11: When at least one entry is on but none matches, the access is allowed if and only if `priv` is machine.
- R12: The address is aligned down to a 4 KiB page before it is compared, so bits [11:0] of `acc_addr` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 34 | Physical byte address of the access |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| priv | input | 2 | Current privilege; 2'b11 is machine |
| cfg_flat | input | 128 | Configuration byte of entry i at bits [8i+7:8i] |
| areg_flat | input | 512 | Address register of entry i (physical address bits [33:2]) at bits [32i+31:32i] |
| allow_q | output | 1 | Registered allow (1) or deny (0) |

## Verification
On every cycle, the assertions check the following:
- the priority select is one-hot or empty and lies within the match vector;
- no entry that is off reports a match;
- the verdicts for an empty table and for a miss follow the privilege level;
- machine mode passes an unlocked deciding entry;
- the reserved kind is always denied.

Only the bench scenarios can show that region bounds are decoded correctly:
- top-of-range edges, including the previous-register rule and an empty range;
- the 4-byte span;
- power-of-two sizing up to the all-ones register;
- the page alignment of the address;
- the one-cycle latency of the output.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam logic [1:0] PRIV_MACH = 2'b11;

  // configuration byte layout
  localparam int CFG_W    = 8;
  localparam int BIT_RD   = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_EX   = 2;
  localparam int MODE_LO  = 3;
  localparam int BIT_LOCK = 7;

  // pick the permission bit that an access kind requires
  function automatic logic perm_for_kind(input logic [2:0] rwx, input acc_e kind);
    logic r;
    case (kind)
      ACC_FETCH: r = rwx[BIT_EX];
      ACC_LOAD:  r = rwx[BIT_RD];
      ACC_STORE: r = rwx[BIT_WR];
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pmpc_region.sv
module pmpc_region
  import pmpc_pkg::*;
#(
  parameter int PA_W = 34,
  localparam int AW  = PA_W - 2
) (
  input  amode_e          mode,
  input  logic [2:0]      rwx,
  input  logic            lock,
  input  acc_e            kind,
  input  logic [AW-1:0]   areg_cur,
  input  logic [AW-1:0]   areg_prev,
  input  logic [PA_W-1:0] pa,
  output logic            on,
  output logic            hit,
  output logic            perm_ok,
  output logic            locked
);

  // half-open range test for a top-of-range entry
  function automatic logic tor_cover(input logic [PA_W-1:0] a,
                                     input logic [AW-1:0] lo_w,
                                     input logic [AW-1:0] hi_w);
    logic [PA_W-1:0] lo, hi;
    lo = {lo_w, 2'b00};
    hi = {hi_w, 2'b00};
    return (a >= lo) && (a < hi);
  endfunction

  // a 4-byte region: word address must be equal
  function automatic logic na4_cover(input logic [PA_W-1:0] a,
                                     input logic [AW-1:0] w);
    return a[PA_W-1:2] == w;
  endfunction

  // low-bit mask of a power-of-two region: trailing ones plus one, plus 2 byte bits
  function automatic logic [PA_W-1:0] napot_mask(input logic [AW-1:0] w);
    logic [AW-1:0] t;
    t = w ^ (w + 1'b1);
    return {t, 2'b11};
  endfunction

  function automatic logic napot_cover(input logic [PA_W-1:0] a,
                                       input logic [AW-1:0] w);
    logic [PA_W-1:0] m;
    m = napot_mask(w);
    return ((a ^ {w, 2'b00}) & ~m) == '0;
  endfunction

  always_comb begin
    on = (mode != AM_OFF);
    case (mode)
      AM_TOR:   hit = tor_cover(pa, areg_prev, areg_cur);
      AM_NA4:   hit = na4_cover(pa, areg_cur);
      AM_NAPOT: hit = napot_cover(pa, areg_cur);
      default:  hit = 1'b0;
    endcase
    perm_ok = perm_for_kind(rwx, kind);
    locked  = lock;
  end

endmodule

// File: rtl/pmpc_first.sv
module pmpc_first #(
  parameter int N_ENT = 16
) (
  input  logic [N_ENT-1:0] hit_vec,
  output logic [N_ENT-1:0] first_oh,
  output logic             hit_any
);

  logic [N_ENT:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_ENT; i++) begin : g_chain
    assign first_oh[i] = hit_vec[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | hit_vec[i];
  end

  assign hit_any = seen[N_ENT];

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmpc_pkg::*;
#(
  parameter int N_ENT     = 16,
  parameter int PA_W      = 34,
  parameter int PAGE_BITS = 12,
  localparam int AW       = PA_W - 2,
  localparam int CFGV_W   = N_ENT * CFG_W,
  localparam int AREGV_W  = N_ENT * AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PA_W-1:0]    acc_addr,
  input  logic [1:0]         acc_kind,
  input  logic [1:0]         priv,
  input  logic [CFGV_W-1:0]  cfg_flat,
  input  logic [AREGV_W-1:0] areg_flat,
  output logic               allow_q
);

  function automatic logic [PA_W-1:0] page_floor(input logic [PA_W-1:0] a);
    logic [PA_W-1:0] m;
    m = {PA_W{1'b1}} << PAGE_BITS;
    return a & m;
  endfunction

  acc_e            kind;
  logic [PA_W-1:0] pa_pg;
  logic            is_mach;

  assign kind    = acc_e'(acc_kind);
  assign pa_pg   = page_floor(acc_addr);
  assign is_mach = (priv == PRIV_MACH);

  // named per-entry events
  logic [N_ENT-1:0] on_vec, hit_vec, perm_vec, lock_vec, grant_vec, first_oh;
  logic [N_ENT-1:0] unused_rsvd;
  logic             hit_any, any_on, sel_grant, grant_comb;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [CFG_W-1:0] cfg_i;
    logic [AW-1:0]    prev_i;

    assign cfg_i          = cfg_flat[i*CFG_W +: CFG_W];
    assign unused_rsvd[i] = ^cfg_i[6:5];

    if (i == 0) begin : g_base
      assign prev_i = '0;
    end else begin : g_link
      assign prev_i = areg_flat[(i-1)*AW +: AW];
    end

    pmpc_region #(.PA_W(PA_W)) u_reg (
      .mode      (amode_e'(cfg_i[MODE_LO +: 2])),
      .rwx       (cfg_i[2:0]),
      .lock      (cfg_i[BIT_LOCK]),
      .kind      (kind),
      .areg_cur  (areg_flat[i*AW +: AW]),
      .areg_prev (prev_i),
      .pa        (pa_pg),
      .on        (on_vec[i]),
      .hit       (hit_vec[i]),
      .perm_ok   (perm_vec[i]),
      .locked    (lock_vec[i])
    );

    assign grant_vec[i] = (is_mach && !lock_vec[i]) || perm_vec[i];
  end

  pmpc_first #(.N_ENT(N_ENT)) u_first (
    .hit_vec  (hit_vec),
    .first_oh (first_oh),
    .hit_any  (hit_any)
  );

  assign any_on    = |on_vec;
  assign sel_grant = |(first_oh & grant_vec);

  always_comb begin
    if (kind == ACC_RSVD)          grant_comb = 1'b0;
    else if (any_on && hit_any)    grant_comb = sel_grant;
    else                           grant_comb = is_mach;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) allow_q <= 1'b0;
    else        allow_q <= grant_comb;
  end

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva #(
  parameter int N_ENT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         priv,
  input logic [1:0]         acc_kind,
  input logic [N_ENT*8-1:0] cfg_flat,
  input logic [N_ENT-1:0]   hit_vec,
  input logic [N_ENT-1:0]   first_oh,
  input logic               any_on,
  input logic               hit_any,
  input logic               allow_q
);

  logic [N_ENT-1:0] off_vec, unlk_vec, unused_cfg;
  logic             mach, kind_ok;

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      off_vec[i]    = (cfg_flat[i*8+3 +: 2] == 2'd0);
      unlk_vec[i]   = !cfg_flat[i*8+7];
      unused_cfg[i] = ^{cfg_flat[i*8 +: 3], cfg_flat[i*8+5 +: 2]};
    end
  end

  assign mach    = (priv == 2'b11);
  assign kind_ok = (acc_kind != 2'd3);

  p_first_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_oh));

  p_first_is_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (first_oh & ~hit_vec) == '0);

  p_off_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & off_vec) == '0);

  p_empty_mach_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_on && mach && kind_ok) |=> allow_q);

  p_empty_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_on && !mach) |=> !allow_q);

  p_miss_user_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (any_on && !hit_any && !mach) |=> !allow_q);

  p_miss_mach_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (any_on && !hit_any && mach && kind_ok) |=> allow_q);

  p_mach_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_any && mach && kind_ok && ((first_oh & unlk_vec) != '0)) |=> allow_q);

  p_rsvd_deny_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !kind_ok |=> !allow_q);

endmodule

bind pmp_checker pmp_checker_sva #(.N_ENT(N_ENT)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .priv     (priv),
  .acc_kind (acc_kind),
  .cfg_flat (cfg_flat),
  .hit_vec  (hit_vec),
  .first_oh (first_oh),
  .any_on   (any_on),
  .hit_any  (hit_any),
  .allow_q  (allow_q)
);

// File: tb/sim_pmp_checker.sv
`timescale 1ns/1ps
module sim_pmp_checker;

  localparam int N = 16;
  localparam logic [1:0] M = 2'b11, U = 2'b00, S = 2'b01;
  localparam logic [1:0] KF = 2'd0, KL = 2'd1, KS = 2'd2, KR = 2'd3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [33:0]  addr = '0;
  logic [1:0]   kind = KL;
  logic [1:0]   priv = M;
  logic [7:0]   cfg_a [N];
  logic [31:0]  ar_a  [N];
  logic [N*8-1:0]  cfg_flat;
  logic [N*32-1:0] areg_flat;
  logic         allow_q;

  int errs = 0, total = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_flat[i*8 +: 8]   = cfg_a[i];
      areg_flat[i*32 +: 32] = ar_a[i];
    end
  end

  pmp_checker u0 (
    .clk(clk), .rst_n(rst_n), .acc_addr(addr), .acc_kind(kind), .priv(priv),
    .cfg_flat(cfg_flat), .areg_flat(areg_flat), .allow_q(allow_q)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic clear_tab();
    for (int i = 0; i < N; i++) begin
      cfg_a[i] = 8'h00;
      ar_a[i]  = 32'h0;
    end
  endtask

  task automatic probe(input logic [33:0] a, input logic [1:0] k, input logic [1:0] p,
                       input logic exp, input string tag);
    @(negedge clk);
    addr = a; kind = k; priv = p;
    @(negedge clk);
    check(allow_q, exp, tag);
  endtask

  task automatic t_reset();
    clear_tab();
    addr = 34'h1000; kind = KL; priv = M;
    repeat (3) @(negedge clk);
    check(allow_q, 1'b0, "R1 held low in reset");
    rst_n = 1'b1;
  endtask

  task automatic t_empty();
    clear_tab();
    probe(34'h0_1234_5000, KL, M, 1'b1, "R3 empty table machine load");
    probe(34'h0_1234_5000, KL, U, 1'b0, "R3 empty table user load");
    probe(34'h0_0000_0000, KF, S, 1'b0, "R3 empty table supervisor fetch");
  endtask

  task automatic t_tor();
    clear_tab();
    cfg_a[0] = 8'h09; ar_a[0] = 32'h400;
    cfg_a[1] = 8'h0A; ar_a[1] = 32'h800;
    probe(34'h0800, KL, U, 1'b1, "R6 tor0 inside");
    probe(34'h1000, KS, U, 1'b1, "R6 tor1 starts at previous top");
    probe(34'h0000, KS, U, 1'b0, "R9 store needs write bit");
    probe(34'h1800, KL, U, 1'b0, "R9 load needs read bit");
    probe(34'h2000, KL, U, 1'b0, "R6 top is exclusive");
    cfg_a[1] = 8'h00;
    cfg_a[2] = 8'h0F; ar_a[2] = 32'hC00;
    probe(34'h2400, KF, U, 1'b1, "R6 base from off predecessor");
    probe(34'h1400, KF, U, 1'b0, "R4 off entry does not match");
    cfg_a[3] = 8'h0F; ar_a[3] = 32'h200;
    probe(34'h4000, KL, U, 1'b0, "R6 top below base is empty");
  endtask

  task automatic t_na4();
    clear_tab();
    cfg_a[0] = 8'h11; ar_a[0] = 32'h4000;
    cfg_a[1] = 8'h11; ar_a[1] = 32'h4401;
    probe(34'h1_0000, KL, U, 1'b1, "R7 na4 base");
    probe(34'h1_0FFC, KL, U, 1'b1, "R12 offset bits dropped");
    probe(34'h1_1004, KL, U, 1'b0, "R12 na4 off page boundary unreachable");
  endtask

  task automatic t_napot();
    clear_tab();
    cfg_a[0] = 8'h1C; ar_a[0] = 32'h0001_1FFF;
    probe(34'h4_F000, KF, U, 1'b1, "R8 napot 64K top page");
    probe(34'h5_0000, KF, U, 1'b0, "R8 napot above region");
    probe(34'h3_F000, KF, U, 1'b0, "R8 napot below region");
    cfg_a[1] = 8'h19; ar_a[1] = 32'hFFFF_FFFF;
    probe(34'h3_FFFF_F000, KL, U, 1'b1, "R8 all ones covers top");
    probe(34'h3_FFFF_F000, KF, U, 1'b0, "R5 first match denies fetch");
  endtask

  task automatic t_prio();
    clear_tab();
    cfg_a[0] = 8'h19; ar_a[0] = 32'h0001_1FFF;
    cfg_a[1] = 8'h1F; ar_a[1] = 32'hFFFF_FFFF;
    probe(34'h4_1000, KS, U, 1'b0, "R5 lower entry denial wins");
    probe(34'h6_0000, KS, U, 1'b1, "R5 higher entry when lower misses");
    cfg_a[0] = 8'h01;
    probe(34'h4_1000, KS, U, 1'b1, "R4 mode off skipped");
  endtask

  task automatic t_mach();
    clear_tab();
    cfg_a[0] = 8'h18; ar_a[0] = 32'h0001_1FFF;
    probe(34'h4_1000, KS, M, 1'b1, "R10 machine bypass unlocked");
    probe(34'h4_1000, KS, S, 1'b0, "R10 supervisor uses bits");
    cfg_a[0] = 8'h98;
    probe(34'h4_1000, KS, M, 1'b0, "R10 locked binds machine");
    cfg_a[0] = 8'h9A;
    probe(34'h4_1000, KS, M, 1'b1, "R10 locked with write bit");
    probe(34'h8_0000, KL, M, 1'b1, "R11 miss machine");
    probe(34'h8_0000, KL, U, 1'b0, "R11 miss user");
  endtask

  task automatic t_kind();
    clear_tab();
    cfg_a[0] = 8'h19; ar_a[0] = 32'hFFFF_FFFF;
    probe(34'h2000, KL, U, 1'b1, "R9 load read bit");
    probe(34'h2000, KS, U, 1'b0, "R9 store no write bit");
    probe(34'h2000, KF, U, 1'b0, "R9 fetch no execute bit");
    probe(34'h2000, KR, U, 1'b0, "R9 reserved kind user");
    cfg_a[0] = 8'h1F;
    probe(34'h2000, KR, M, 1'b0, "R9 reserved kind machine");
    cfg_a[0] = 8'h1C;
    probe(34'h2000, KF, U, 1'b1, "R9 fetch execute bit");
    probe(34'h2000, KL, U, 1'b0, "R9 load without read bit");
  endtask

  task automatic t_timing();
    clear_tab();
    probe(34'h3000, KL, M, 1'b1, "R2 settle allow");
    @(negedge clk);
    priv = U;
    #1;
    check(allow_q, 1'b1, "R2 holds until edge");
    @(negedge clk);
    check(allow_q, 1'b0, "R2 updates after edge");
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errs++; total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_empty();
    t_tor();
    t_na4();
    t_napot();
    t_prio();
    t_mach();
    t_kind();
    t_timing();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule